// File: doc/BRIEF.md
# SDRAM Forced-Command Sequencer

This block sits between a simple host access port and the command pins of a single-data-rate SDRAM. A small mode register decides what the next host accesses mean. In normal mode an access is passed on to a separate burst engine, and this block issues no command for it. In one of the forced modes, an access moves no data. The block instead issues exactly one SDRAM command: NOP, precharge of all banks, mode-register load, extended mode-register load, auto-refresh or deep power-down. Software steps through the power-up initialisation of the memory this way, one access per command.

The block also holds a 32-bit geometry and timing word. The column, row and bank counts decide where the bank index sits in an access address. The precharge, refresh and write-recovery counts decide how long the block holds off the next command. The remaining timing fields and the CAS latency are stored only and presented on `cfg_word` for the burst engine.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held and after its release, sd_cke is 1, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP), acc_ack and norm_pass are 0, the active mode is normal, and cfg_word reads 32'h5945_2262.
- R2: Each accepted access in a forced mode drives the command pins for one cycle, in the cycle that acc_ack is high. The encoding is {cs_n,ras_n,cas_n,we_n}. Mode 1 gives 0111 (NOP), mode 2 gives 0010 (precharge), mode 3 and mode 5 give 0000 (mode load), mode 4 gives 0001 (refresh) and mode 6 gives 0110 (deep power-down). The kind of access does not matter.
- R3: A value written to the mode register stays pending. It becomes active on the next host write access, and that write already uses it. Read accesses made before that write use the previously active mode.
- R4: Mode 0 and the reserved mode 7 mean normal. In normal mode an access is acked with norm_pass high for that cycle, and the command pins stay at NOP.
- R5: A refresh access issues NOP instead of refresh unless a precharge has been issued since reset or since the last deep power-down.
- R6: A precharge drives sd_a with only bit 10 set and sd_ba at 0. A mode-load access (mode 3) drives sd_ba at 0 and sd_a with acc_addr[12:0].
- R7: An extended mode load (mode 5) drives sd_a with acc_addr[12:0]. It drives sd_ba with the two address bits starting at bit (column bits + row bits). Bit 1 of sd_ba is forced to 0 when the geometry selects 2 banks.
- R8: After a command, the next accepted access comes no earlier than max(D,1)+1 cycles later. D is trp after a precharge and trfc after a refresh. After a mode load or extended mode load, D is max(twr+trp, 2). After any other access, D is 0.
- R9: A deep power-down drives sd_cke to 0 in the same cycle as its command, and sd_cke stays 0 until reset. While powered down, every access is acked with NOP and without norm_pass.
- R10: acc_ack is a one-cycle pulse for each accepted access. A command never occupies two consecutive cycles.
- R11: A config write takes effect one cycle later. The word layout, from bit 0 upward, is: trp[3:0], trfc[7:4], twr[11:8], trcd[15:12], tras[19:16], txsr[23:20], column code[25:24] (8+code bits), row code[27:26] (11+code bits, code 3 read as 13), four_banks[28], cas[30:29], spare[31]. cfg_word returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | New mode value |
| cfg_we | input | 1 | Write strobe for the geometry/timing word |
| cfg_wdata | input | 32 | New geometry/timing word |
| cfg_word | output | 32 | Stored geometry/timing word |
| acc_req | input | 1 | Host access request, held until acked |
| acc_we | input | 1 | 1 for a write access |
| acc_addr | input | 26 | Host word address |
| acc_ack | output | 1 | Access accepted (one-cycle pulse) |
| norm_pass | output | 1 | Access forwarded to the burst engine |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Address lines |

## Verification
The assertions assume that the host holds acc_req, acc_we and acc_addr steady from the request until acc_ack. They also assume that the mode register is never written in the same cycle as the arming write. The random stimulus honours both. It waits for every ack before it starts a new access, and it places mode and config writes only between accesses. Deep power-down cannot be left without a reset, so the random phase uses only modes other than 6. Deep power-down is exercised once, as the final directed case.

// File: rtl/sdcs_pkg.sv
// Shared types and helpers for the SDRAM forced-command sequencer.
// Assumes a two-bit bank address and four-bit timing fields.
package sdcs_pkg;
    localparam int CFG_W  = 32;
    localparam int TIME_W = 4;
    localparam int BA_W   = 2;
    localparam int HOLD_W = TIME_W + 1;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h5945_2262;

    typedef enum logic [2:0] {
        M_NORMAL  = 3'd0,
        M_NOP     = 3'd1,
        M_PRECH   = 3'd2,
        M_LOADMR  = 3'd3,
        M_REFRESH = 3'd4,
        M_LOADEXT = 3'd5,
        M_DEEPPD  = 3'd6,
        M_RSVD    = 3'd7
    } mode_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        C_LMR = 4'b0000,
        C_REF = 4'b0001,
        C_PRE = 4'b0010,
        C_DPD = 4'b0110,
        C_NOP = 4'b0111
    } cmd_e;

    typedef struct packed {
        logic              spare;
        logic [1:0]        cas;
        logic              four_banks;
        logic [1:0]        row_code;
        logic [1:0]        col_code;
        logic [TIME_W-1:0] txsr;
        logic [TIME_W-1:0] tras;
        logic [TIME_W-1:0] trcd;
        logic [TIME_W-1:0] twr;
        logic [TIME_W-1:0] trfc;
        logic [TIME_W-1:0] trp;
    } geom_t;

    // Number of column address bits for a column code.
    function automatic logic [5:0] col_bits(input logic [1:0] code);
        return 6'd8 + {4'd0, code};
    endfunction

    // Number of row address bits for a row code; code 3 reads as 13.
    function automatic logic [5:0] row_bits(input logic [1:0] code);
        return (code == 2'd3) ? 6'd13 : 6'd11 + {4'd0, code};
    endfunction
endpackage

// File: rtl/sdcs_mode_reg.sv
// Mode register with a pending slot.
// A written mode waits until the next accepted host write, which already uses it.
// Assumes acc_fire is a single-cycle acceptance strobe.
module sdcs_mode_reg
    import sdcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [2:0] mode_wdata,
    input  logic       acc_fire,
    input  logic       acc_we,
    output mode_e      eff_mode
);
    mode_e active_q;
    mode_e pend_q;
    logic  pend_v_q;
    logic  arm;

    // Decide whether the current access arms the pending mode.
    always_comb begin
        arm      = acc_we && pend_v_q;
        eff_mode = arm ? pend_q : active_q;
    end

    // Hold the active and pending modes; a new write overrides arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= M_NORMAL;
            pend_q   <= M_NORMAL;
            pend_v_q <= 1'b0;
        end else begin
            if (acc_fire && arm) begin
                active_q <= pend_q;
                pend_v_q <= 1'b0;
            end
            if (mode_we) begin
                pend_q   <= mode_e'(mode_wdata);
                pend_v_q <= 1'b1;
            end
        end
    end

    p_arm_consumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && arm && !mode_we) |=> !pend_v_q);
    p_write_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> pend_v_q);
endmodule

// File: rtl/sdcs_cmd_enc.sv
// Combinational translation of the effective mode and access address into
// an SDRAM command, its bank/address lines and the hold-off that follows it.
// Assumes the address is wide enough to hold the largest bank position.
module sdcs_cmd_enc
    import sdcs_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int ROW_W  = 13
) (
    input  mode_e              eff_mode,
    input  logic               prech_seen,
    input  logic               powered_down,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         col_code,
    input  logic [1:0]         row_code,
    input  logic               four_banks,
    input  logic [TIME_W-1:0]  trp,
    input  logic [TIME_W-1:0]  trfc,
    input  logic [TIME_W-1:0]  twr,
    output cmd_e               cmd,
    output logic [BA_W-1:0]    ba,
    output logic [ROW_W-1:0]   a,
    output logic [HOLD_W-1:0]  hold,
    output logic               is_normal
);
    localparam int AP_BIT = 10;

    logic [5:0]        bank_lsb;
    logic [ADDR_W-1:0] shifted;
    logic [BA_W-1:0]   ext_ba;
    logic [HOLD_W-1:0] mr_hold;

    // Locate the bank index above the column and row bits.
    always_comb begin
        bank_lsb = col_bits(col_code) + row_bits(row_code);
        shifted  = addr >> bank_lsb;
        ext_ba   = shifted[BA_W-1:0];
        if (!four_banks) ext_ba[1] = 1'b0;
        mr_hold  = {1'b0, twr} + {1'b0, trp};
        if (mr_hold < HOLD_W'(2)) mr_hold = HOLD_W'(2);
    end

    // Select the command and its operands for the effective mode.
    always_comb begin
        cmd       = C_NOP;
        ba        = '0;
        a         = '0;
        hold      = '0;
        is_normal = 1'b0;
        if (!powered_down) begin
            case (eff_mode)
                M_NOP: cmd = C_NOP;
                M_PRECH: begin
                    cmd       = C_PRE;
                    a[AP_BIT] = 1'b1;
                    hold      = {1'b0, trp};
                end
                M_LOADMR: begin
                    cmd  = C_LMR;
                    a    = addr[ROW_W-1:0];
                    hold = mr_hold;
                end
                M_REFRESH: begin
                    if (prech_seen) begin
                        cmd  = C_REF;
                        hold = {1'b0, trfc};
                    end
                end
                M_LOADEXT: begin
                    cmd  = C_LMR;
                    ba   = ext_ba;
                    a    = addr[ROW_W-1:0];
                    hold = mr_hold;
                end
                M_DEEPPD: cmd = C_DPD;
                default:  is_normal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sdcs_holdoff.sv
// Down-counter that blocks new commands until the required delay has elapsed.
// Assumes load is asserted only when busy is low.
module sdcs_holdoff #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] delay,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a new command, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= delay;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
endmodule

// File: rtl/sdram_cmd_seq.sv
// Top of the SDRAM forced-command sequencer.
// It accepts one host access at a time and registers the resulting command
// onto the SDRAM pins for one cycle.
// Assumes the host holds its request and operands steady until acc_ack.
module sdram_cmd_seq
    import sdcs_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [2:0]        mode_wdata,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_word,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_ack,
    output logic              norm_pass,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_a
);
    geom_t             geom_q;
    cmd_e              cmd_q, cmd_n;
    logic [BA_W-1:0]   ba_q, ba_n;
    logic [ROW_W-1:0]  a_q, a_n;
    logic [HOLD_W-1:0] hold_n;
    logic              ack_q, norm_q, prech_q, cke_q;
    logic              is_normal, busy, fire;
    mode_e             eff_mode;

    assign fire = acc_req && !ack_q && !busy;

    sdcs_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .acc_fire   (fire),
        .acc_we     (acc_we),
        .eff_mode   (eff_mode)
    );

    sdcs_cmd_enc #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_enc (
        .eff_mode     (eff_mode),
        .prech_seen   (prech_q),
        .powered_down (!cke_q),
        .addr         (acc_addr),
        .col_code     (geom_q.col_code),
        .row_code     (geom_q.row_code),
        .four_banks   (geom_q.four_banks),
        .trp          (geom_q.trp),
        .trfc         (geom_q.trfc),
        .twr          (geom_q.twr),
        .cmd          (cmd_n),
        .ba           (ba_n),
        .a            (a_n),
        .hold         (hold_n),
        .is_normal    (is_normal)
    );

    sdcs_holdoff #(.CNT_W(HOLD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire),
        .delay (hold_n),
        .busy  (busy)
    );

    // Hold the geometry and timing word.
    always_ff @(posedge clk) begin
        if (!rst_n)      geom_q <= geom_t'(CFG_RESET);
        else if (cfg_we) geom_q <= geom_t'(cfg_wdata);
    end

    // Register the command pins, the handshake and the precharge/power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= C_NOP;
            ba_q    <= '0;
            a_q     <= '0;
            ack_q   <= 1'b0;
            norm_q  <= 1'b0;
            prech_q <= 1'b0;
            cke_q   <= 1'b1;
        end else begin
            ack_q  <= fire;
            norm_q <= fire && is_normal;
            if (fire) begin
                cmd_q <= cmd_n;
                ba_q  <= ba_n;
                a_q   <= a_n;
                if (cmd_n == C_PRE) prech_q <= 1'b1;
                if (cmd_n == C_DPD) begin
                    prech_q <= 1'b0;
                    cke_q   <= 1'b0;
                end
            end else begin
                cmd_q <= C_NOP;
                ba_q  <= '0;
                a_q   <= '0;
            end
        end
    end

    assign cfg_word  = geom_q;
    assign acc_ack   = ack_q;
    assign norm_pass = norm_q;
    assign sd_cke    = cke_q;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_a      = a_q;

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |=> !acc_ack);
    p_cmd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != C_NOP) |=> (cmd_q == C_NOP));
    p_cmd_has_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != C_NOP) |-> acc_ack);
    p_ref_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_REF) |-> prech_q);
    p_norm_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        norm_pass |-> (acc_ack && cmd_q == C_NOP));
    p_cke_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (cmd_q == C_DPD));
    p_cke_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |=> !sd_cke);
    p_down_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && !$fell(sd_cke)) |-> (cmd_q == C_NOP && !norm_pass));
endmodule

// File: tb/sim_sdram_cmd_seq.sv
// Self-checking bench for sdram_cmd_seq: directed corner cases plus
// seeded random mode/config/access traffic against a bench reference model.
module sim_sdram_cmd_seq;
    localparam int AW = 26;
    localparam int RW = 13;
    localparam logic [3:0] E_NOP = 4'b0111, E_PRE = 4'b0010, E_REF = 4'b0001,
                           E_LMR = 4'b0000, E_DPD = 4'b0110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0;
    logic [2:0]    mode_wdata = '0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_word;
    logic          acc_req = 1'b0, acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_ack, norm_pass, sd_cke;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]    sd_ba;
    logic [RW-1:0] sd_a;

    int errors = 0, checks = 0, cyc = 0;

    // Reference model state.
    logic [2:0]  m_active = 3'd0, m_pend = 3'd0;
    logic        m_pendv = 1'b0, m_prech = 1'b0, m_down = 1'b0;
    logic [31:0] g_word = 32'h5945_2262;
    int          prev_ack = 0, cur_ack = 0, prev_gap = 0, cur_gap = 0;

    sdram_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_word(cfg_word),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_ack(acc_ack), .norm_pass(norm_pass), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int max_i(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Bank index position from the geometry word (R7).
    function automatic logic [1:0] exp_bank(input logic [AW-1:0] addr);
        int cb, rb;
        logic [AW-1:0] s;
        logic [1:0] b;
        cb = 8 + int'(g_word[25:24]);
        rb = (g_word[27:26] == 2'd3) ? 13 : 11 + int'(g_word[27:26]);
        s = addr >> (cb + rb);
        b = s[1:0];
        if (!g_word[28]) b[1] = 1'b0;
        return b;
    endfunction

    // Predict one access and advance the model (R2..R9).
    task automatic model_access(input logic we, input logic [AW-1:0] addr,
                                output logic [3:0] c, output logic [1:0] b,
                                output logic [RW-1:0] a, output logic n,
                                output int gap);
        logic [2:0] m;
        int d, trp, trfc, twr;
        trp  = int'(g_word[3:0]);
        trfc = int'(g_word[7:4]);
        twr  = int'(g_word[11:8]);
        m = (we && m_pendv) ? m_pend : m_active;
        if (we && m_pendv) begin
            m_active = m_pend;
            m_pendv  = 1'b0;
        end
        c = E_NOP; b = 2'd0; a = '0; n = 1'b0; d = 0;
        if (!m_down) begin
            case (m)
                3'd1: c = E_NOP;
                3'd2: begin c = E_PRE; a = 13'h0400; d = trp; m_prech = 1'b1; end
                3'd3: begin c = E_LMR; a = addr[RW-1:0]; d = max_i(twr + trp, 2); end
                3'd4: if (m_prech) begin c = E_REF; d = trfc; end
                3'd5: begin c = E_LMR; a = addr[RW-1:0]; b = exp_bank(addr);
                            d = max_i(twr + trp, 2); end
                3'd6: begin c = E_DPD; m_down = 1'b1; m_prech = 1'b0; end
                default: n = 1'b1;
            endcase
        end
        gap = max_i(d, 1) + 1;
    endtask

    task automatic write_mode(input logic [2:0] v);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
        m_pend = v; m_pendv = 1'b1;
    endtask

    task automatic write_cfg(input logic [31:0] w, input logic check);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        g_word = w;
        if (check) chk(cfg_word, w, "R11 cfg word");
    endtask

    // One host access; checks the command pins in the ack cycle.
    task automatic do_access(input logic we, input logic [AW-1:0] addr, input string req);
        logic [3:0] c; logic [1:0] b; logic [RW-1:0] a; logic n; int gap; int w;
        model_access(we, addr, c, b, a, n, gap);
        acc_req = 1'b1; acc_we = we; acc_addr = addr;
        w = 0;
        do begin
            @(negedge clk);
            w = w + 1;
        end while (!acc_ack && w < 80);
        if (!acc_ack) chk(32'd0, 32'd1, {req, " ack"});
        prev_ack = cur_ack; cur_ack = cyc;
        prev_gap = cur_gap; cur_gap = gap;
        chk({28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, c}, {req, " cmd"});
        chk({30'd0, sd_ba}, {30'd0, b}, {req, " bank"});
        chk({19'd0, sd_a}, {19'd0, a}, {req, " addr"});
        chk({31'd0, norm_pass}, {31'd0, n}, {req, " norm_pass"});
        chk({31'd0, sd_cke}, {31'd0, !m_down}, {req, " cke"});
        acc_req = 1'b0;
    endtask

    task automatic chk_gap(input string req);
        chk(cur_ack - prev_ack, prev_gap, req);
    endtask

    initial begin
        int rs;
        rs = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        // R1: reset values while in reset and just after release.
        chk({31'd0, sd_cke}, 32'd1, "R1 cke in reset");
        chk({28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, E_NOP}, "R1 nop in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({30'd0, acc_ack, norm_pass}, 32'd0, "R1 ack/norm idle");
        chk(cfg_word, 32'h5945_2262, "R1 cfg reset value");

        // R4: normal mode after reset.
        do_access(1'b1, 26'h12345, "R4 normal write");
        // R5: refresh with no precharge yet.
        write_mode(3'd4);
        do_access(1'b1, 26'h0, "R5 refresh without precharge");
        // R3: read keeps old mode, write arms new one.
        write_mode(3'd2);
        do_access(1'b0, 26'h3, "R3 read keeps old mode");
        do_access(1'b1, 26'h3, "R3 R6 arming write gives precharge");
        do_access(1'b0, 26'h3, "R2 precharge by read");
        chk_gap("R8 precharge gap");
        write_mode(3'd4);
        do_access(1'b1, 26'h0, "R2 refresh after precharge");
        do_access(1'b0, 26'h0, "R2 second refresh");
        chk_gap("R8 refresh gap");
        write_mode(3'd3);
        do_access(1'b1, 26'h1abc5, "R6 mode load");
        do_access(1'b1, 26'h00033, "R6 mode load again");
        chk_gap("R8 mode load gap");
        // Zero timing: minimum hold of 2 after mode load, gap 2 after precharge.
        write_cfg(32'h1000_0000, 1'b1);
        do_access(1'b1, 26'h00021, "R6 mode load zero timing");
        do_access(1'b0, 26'h00022, "R6 mode load zero timing 2");
        chk_gap("R8 mode load minimum hold");
        write_mode(3'd5);
        do_access(1'b1, (26'd2 << 19) | 26'h55, "R7 extended load bank 2");
        write_cfg(32'h0400_0000, 1'b1);
        do_access(1'b0, (26'd3 << 20) | 26'h7, "R7 extended load two banks");
        write_mode(3'd1);
        do_access(1'b1, 26'h1, "R2 nop mode");
        do_access(1'b0, 26'h2, "R2 nop mode read");
        chk_gap("R8 nop gap");
        write_mode(3'd7);
        do_access(1'b1, 26'h9, "R4 reserved mode is normal");

        // Random traffic, deep power-down excluded.
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 2) begin
                logic [2:0] mv;
                mv = 3'($urandom_range(0, 6));
                if (mv == 3'd6) mv = 3'd7;
                write_mode(mv);
            end else if (op == 2) begin
                write_cfg($urandom, 1'b1);
            end else begin
                do_access(1'($urandom_range(0, 1)), AW'($urandom), "R2 R3 R7 random access");
            end
        end

        // R9: deep power-down.
        write_mode(3'd6);
        do_access(1'b1, 26'h0, "R9 deep power-down");
        do_access(1'b0, 26'h0, "R9 access while down");
        write_mode(3'd0);
        do_access(1'b1, 26'h4, "R9 normal while down");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule